// File: doc/BRIEF.md
# Line-Code Error Injection Encoder

This block turns a unipolar NRZ bit stream into a bipolar positive/negative rail pair. Data arrives one bit per enabled clock. A mode input picks three-zero substitution for T3 lines (B3ZS) or four-zero substitution for E3 lines (HDB3). A bypass input puts the block in unipolar mode, where the data goes straight to the positive rail.

Two control bits each arm a single deliberate line-code error. One is a bipolar violation (BPV). The other is an excessive-zero (EXZ) event. Each armed error is placed at the next point in the stream where it can legally occur. A BPV goes onto the third mark of the next run of three ones. An EXZ is made by dropping the next substitution codeword, so those zeros go out as a plain zero run. In manual mode the control bits only enable the error types, and each toggle of an external strobe fires one error of every enabled type.

A test or maintenance controller uses the block to check that a far-end receiver detects and counts line-code errors. Each error is injected exactly once per request.

Top module: `line_err_encoder`

## Requirements
- R1: The rails are registered and reset to 0. The code for the input bit accepted on one enabled clock appears on the rails four enabled clocks later. The rails hold their value on clocks where bit_en is low.
- R2: The two rails are never high together. Input ones become marks of alternating polarity, and the first mark after reset is positive. Apart from the errors of R5 and R6, an input zero gives no pulse except inside a substitution codeword.
- R3: With mode_e3 = 0, every run of three input zeros is sent as 00V or B0V. The choice is 00V when the count of pulses since the last substitution violation is odd, and B0V when it is even (the count is zero at reset). V has the polarity of the preceding pulse, and B alternates like a normal mark.
- R4: With mode_e3 = 1, every run of four input zeros is sent as 000V when that count is odd, and as B00V when it is even.
- R5: In automatic mode (manual_mode = 0), a 0-to-1 change of bpv_ctl arms one BPV. The BPV is the third of the next three consecutive input ones, sent with the same polarity as the preceding mark. It counts as an ordinary pulse for the substitution parity.
- R6: In automatic mode, a 0-to-1 change of exz_ctl arms one EXZ. The next substitution codeword is left out, so its three zeros (T3) or four zeros (E3) go out as plain zeros. Zero counting then restarts with the next input zero.
- R7: An armed request stays pending for any number of bit times until it is executed. A further 0-to-1 change of the same control bit while the request is pending adds no second error.
- R8: In manual mode, each change of level on strobe arms one error of every type whose control bit is high. Edges on the control bits arm nothing, and a type whose control bit is low is never armed.
- R9: With unipolar = 1, the positive rail carries the delayed data and the negative rail stays 0. No substitution is made, any pending error is dropped, and neither control bit nor strobe arms anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Accepts data_in and advances the line by one bit |
| data_in | input | 1 | Unipolar NRZ transmit bit |
| mode_e3 | input | 1 | 1 selects four-zero substitution (HDB3), 0 selects three-zero substitution (B3ZS) |
| unipolar | input | 1 | 1 bypasses the line coding |
| manual_mode | input | 1 | 1 makes strobe toggles fire the enabled errors |
| bpv_ctl | input | 1 | Bipolar-violation request or enable |
| exz_ctl | input | 1 | Excessive-zero request or enable |
| strobe | input | 1 | Manual error strobe; each change of level counts |
| pos_out | output | 1 | Positive rail |
| neg_out | output | 1 | Negative rail |

## Verification
The rail code for input bit i is due on the enabled edge four accepted bits later. The bench samples the rails half a clock after every enabled edge and compares output sample i+4 with input bit i. A control or strobe change is registered on the first clock edge after it. The bench therefore changes these inputs on an idle clock, ahead of the bit where the error may land. Each BPV and EXZ is then counted from the decoded rails over the whole run, so that a request which fires late or twice is still caught.

// File: rtl/line_err_encoder.sv
module line_err_encoder (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic data_in,
  input  logic mode_e3,
  input  logic unipolar,
  input  logic manual_mode,
  input  logic bpv_ctl,
  input  logic exz_ctl,
  input  logic strobe,
  output logic pos_out,
  output logic neg_out
);

  localparam logic [1:0] C_ZERO = 2'd0;
  localparam logic [1:0] C_MARK = 2'd1;
  localparam logic [1:0] C_VIOL = 2'd2;
  localparam logic [1:0] C_BPV  = 2'd3;

  logic [1:0] s0, s1, s2, s3;
  logic [2:0] zrun;
  logic [1:0] orun;
  logic       parity, last_pol;
  logic       bpv_d, exz_d, strobe_d;
  logic       bpv_pend, exz_pend;

  wire       tog     = strobe ^ strobe_d;
  wire       bpv_arm = !unipolar && (manual_mode ? (tog && bpv_ctl) : (bpv_ctl && !bpv_d));
  wire       exz_arm = !unipolar && (manual_mode ? (tog && exz_ctl) : (exz_ctl && !exz_d));
  wire [2:0] zlim    = mode_e3 ? 3'd4 : 3'd3;
  wire       zhit    = bit_en && !unipolar && !data_in && (zrun + 3'd1 == zlim);
  wire       sub_go  = zhit && !exz_pend;
  wire       exz_fire = zhit && exz_pend;
  wire       bpv_fire = bit_en && !unipolar && data_in && (orun == 2'd2) && bpv_pend;
  wire       put_b_t3 = sub_go && !parity && !mode_e3;
  wire       put_b_e3 = sub_go && !parity && mode_e3;

  logic [1:0] new_code;
  always_comb begin
    if (data_in) new_code = bpv_fire ? C_BPV : C_MARK;
    else         new_code = sub_go ? C_VIOL : C_ZERO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpv_d    <= 1'b0;
      exz_d    <= 1'b0;
      strobe_d <= 1'b0;
      bpv_pend <= 1'b0;
      exz_pend <= 1'b0;
    end else begin
      bpv_d    <= bpv_ctl;
      exz_d    <= exz_ctl;
      strobe_d <= strobe;
      bpv_pend <= unipolar ? 1'b0 : ((bpv_pend && !bpv_fire) || bpv_arm);
      exz_pend <= unipolar ? 1'b0 : ((exz_pend && !exz_fire) || exz_arm);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= C_ZERO; s1 <= C_ZERO; s2 <= C_ZERO; s3 <= C_ZERO;
      zrun <= 3'd0;
      orun <= 2'd0;
      parity <= 1'b0;
    end else if (bit_en) begin
      s0 <= new_code;
      s1 <= s0;
      s2 <= put_b_t3 ? C_MARK : s1;
      s3 <= put_b_e3 ? C_MARK : s2;
      zrun <= (unipolar || data_in || zhit) ? 3'd0 : zrun + 3'd1;
      orun <= (unipolar || !data_in) ? 2'd0 : ((orun == 2'd2) ? orun : orun + 2'd1);
      if (sub_go)                     parity <= 1'b0;
      else if (data_in && !unipolar) parity <= !parity;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_out  <= 1'b0;
      neg_out  <= 1'b0;
      last_pol <= 1'b0;
    end else if (bit_en) begin
      if (s3 == C_ZERO) begin
        pos_out <= 1'b0;
        neg_out <= 1'b0;
      end else if (unipolar) begin
        pos_out <= 1'b1;
        neg_out <= 1'b0;
      end else if (s3 == C_MARK) begin
        pos_out  <= !last_pol;
        neg_out  <= last_pol;
        last_pol <= !last_pol;
      end else begin
        pos_out <= last_pol;
        neg_out <= !last_pol;
      end
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pos_out) && $stable(neg_out));
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_out && neg_out));
  p_sub_site_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sub_go && !mode_e3 |-> s0 == C_ZERO && s1 == C_ZERO);
  p_sub_site_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sub_go && mode_e3 |-> s0 == C_ZERO && s1 == C_ZERO && s2 == C_ZERO);
  p_bpv_site_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bpv_fire |-> (s0 == C_MARK || s0 == C_BPV) && (s1 == C_MARK || s1 == C_BPV));
  p_exz_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exz_fire && !exz_arm |=> !exz_pend);
  p_pend_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bpv_pend && !bpv_fire && !unipolar |=> bpv_pend);
  p_uni_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unipolar |=> !bpv_pend && !exz_pend);
  p_uni_rail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && unipolar |=> !neg_out);

endmodule

// File: tb/line_err_encoder_test.sv
module line_err_encoder_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, data_in = 1'b0, mode_e3 = 1'b0, unipolar = 1'b0, manual_mode = 1'b0;
  logic bpv_ctl = 1'b0, exz_ctl = 1'b0, strobe = 1'b0;
  logic pos_out, neg_out;

  int checks = 0;
  int errors = 0;

  logic cap_p [0:511];
  logic cap_n [0:511];
  logic din   [0:511];
  int   ncap = 0;
  int   nin = 0;

  // [22] e3, [21] arm bpv, [20] arm exz, [19:4] bits (MSB first), [3:2] expected BPVs, [1:0] expected EXZs
  localparam logic [22:0] VEC [0:7] = '{
    {1'b0, 1'b0, 1'b0, 16'b1010110001011011, 2'd0, 2'd0},
    {1'b0, 1'b1, 1'b0, 16'b1110001110000111, 2'd1, 2'd0},
    {1'b0, 1'b0, 1'b1, 16'b1000000000000001, 2'd0, 2'd1},
    {1'b1, 1'b0, 1'b0, 16'b1100001000001001, 2'd0, 2'd0},
    {1'b1, 1'b0, 1'b1, 16'b1000000000110101, 2'd0, 2'd1},
    {1'b1, 1'b1, 1'b0, 16'b1111111100000000, 2'd1, 2'd0},
    {1'b0, 1'b1, 1'b1, 16'b0111000101100000, 2'd1, 2'd1},
    {1'b1, 1'b0, 1'b0, 16'b0000000000000000, 2'd0, 2'd0}
  };

  line_err_encoder uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .data_in(data_in), .mode_e3(mode_e3),
    .unipolar(unipolar), .manual_mode(manual_mode), .bpv_ctl(bpv_ctl), .exz_ctl(exz_ctl),
    .strobe(strobe), .pos_out(pos_out), .neg_out(neg_out)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; data_in = 1'b0;
    bpv_ctl = 1'b0; exz_ctl = 1'b0; strobe = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ncap = 0; nin = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    data_in = b; bit_en = 1'b1;
    din[nin] = b; nin++;
    @(negedge clk);
    bit_en = 1'b0;
    cap_p[ncap] = pos_out; cap_n[ncap] = neg_out; ncap++;
  endtask

  task automatic send_tail();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
  endtask

  task automatic idle_edge();
    @(negedge clk);
  endtask

  task automatic analyze(input int a, input int b, input int k, input bit chkpar,
                         output int mism, output int bpv, output int exz, output int perr, output int both);
    logic dec [0:511];
    int lastp, psv, zr, s;
    lastp = 0; psv = 0; zr = 0;
    mism = 0; bpv = 0; exz = 0; perr = 0; both = 0;
    for (int t = a; t < b; t++) begin
      if (cap_p[t] && cap_n[t]) both++;
      s = cap_p[t] ? 1 : (cap_n[t] ? -1 : 0);
      dec[t] = (s != 0);
      if (s == 0) begin
        zr++;
        if (zr == k) exz++;
      end else begin
        zr = 0;
        if (lastp != 0 && s == lastp) begin
          if (t > a && !cap_p[t-1] && !cap_n[t-1]) begin
            for (int j = 0; j < k; j++) if (t - j >= a) dec[t-j] = 1'b0;
            if (chkpar && (psv % 2 == 0)) perr++;
            psv = 0;
          end else begin
            bpv++;
            psv++;
          end
        end else begin
          lastp = s;
          psv++;
        end
      end
    end
    for (int t = a; t < b; t++) if (dec[t] != din[t-4]) mism++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int mism, bpv, exz, perr, both;
    string rq;

    // Table walk: R2, R3, R4, R5, R6
    for (int v = 0; v < 8; v++) begin
      mode_e3 = VEC[v][22]; unipolar = 1'b0; manual_mode = 1'b0;
      do_reset();
      bpv_ctl = VEC[v][21]; exz_ctl = VEC[v][20];
      idle_edge();
      for (int k = 15; k >= 0; k--) send_bit(VEC[v][4+k]);
      send_tail();
      bpv_ctl = 1'b0; exz_ctl = 1'b0;
      analyze(4, ncap, mode_e3 ? 4 : 3, 1'b1, mism, bpv, exz, perr, both);
      rq = mode_e3 ? "R4" : "R3";
      check(mism == 0, rq, $sformatf("vec %0d decoded data mismatches", v), mism, 0);
      check(perr == 0, rq, $sformatf("vec %0d substitution parity errors", v), perr, 0);
      check(both == 0, "R2", $sformatf("vec %0d both rails high", v), both, 0);
      check(bpv == int'(VEC[v][3:2]), "R5", $sformatf("vec %0d BPV count", v), bpv, int'(VEC[v][3:2]));
      check(exz == int'(VEC[v][1:0]), "R6", $sformatf("vec %0d EXZ count", v), exz, int'(VEC[v][1:0]));
    end

    // R1: reset state, latency, hold
    mode_e3 = 1'b0;
    do_reset();
    check(pos_out == 1'b0 && neg_out == 1'b0, "R1", "rails after reset", {pos_out, neg_out}, 0);
    send_bit(1'b1);
    for (int k = 0; k < 4; k++) send_bit(1'b0);
    for (int k = 0; k < 4; k++)
      check(cap_p[k] == 1'b0 && cap_n[k] == 1'b0, "R1", $sformatf("rails before latency at %0d", k), {cap_p[k], cap_n[k]}, 0);
    check(cap_p[4] == 1'b1 && cap_n[4] == 1'b0, "R1", "first mark four bits later, positive", {cap_p[4], cap_n[4]}, 2);
    repeat (3) idle_edge();
    check(pos_out == cap_p[4] && neg_out == cap_n[4], "R1", "rails held while bit_en low",
          {pos_out, neg_out}, {cap_p[4], cap_n[4]});

    // R7: pending across bit times, no stacking
    do_reset();
    bpv_ctl = 1'b1; idle_edge();
    for (int k = 0; k < 12; k++) send_bit(k[0]);
    bpv_ctl = 1'b0; idle_edge();
    bpv_ctl = 1'b1; idle_edge();
    for (int k = 0; k < 9; k++) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    analyze(4, ncap, 3, 1'b1, mism, bpv, exz, perr, both);
    check(bpv == 1, "R7", "single BPV after re-arm while pending", bpv, 1);
    check(mism == 0, "R7", "decoded data around pending BPV", mism, 0);

    // R8: manual mode
    manual_mode = 1'b1;
    do_reset();
    bpv_ctl = 1'b1; idle_edge();
    for (int k = 0; k < 3; k++) send_bit(1'b1);
    send_bit(1'b0);
    strobe = ~strobe; idle_edge();
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    send_bit(1'b0);
    strobe = ~strobe; idle_edge();
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    send_bit(1'b0);
    bpv_ctl = 1'b0; idle_edge();
    strobe = ~strobe; idle_edge();
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    send_bit(1'b0);
    exz_ctl = 1'b1; idle_edge();
    strobe = ~strobe; idle_edge();
    send_bit(1'b1);
    for (int k = 0; k < 6; k++) send_bit(1'b0);
    send_bit(1'b1);
    send_tail();
    analyze(4, ncap, 3, 1'b1, mism, bpv, exz, perr, both);
    check(bpv == 2, "R8", "BPVs from strobe toggles only while enabled", bpv, 2);
    check(exz == 1, "R8", "EXZ from one enabled toggle", exz, 1);
    check(mism == 0, "R8", "decoded data in manual mode", mism, 0);
    manual_mode = 1'b0; exz_ctl = 1'b0; strobe = 1'b0;

    // R9: unipolar bypass, controls without effect
    unipolar = 1'b1;
    do_reset();
    bpv_ctl = 1'b1; exz_ctl = 1'b1; idle_edge();
    for (int k = 15; k >= 0; k--) send_bit(16'b1110000010111111 >> k);
    mism = 0; both = 0;
    for (int i = 0; i + 4 < ncap; i++) begin
      if (cap_p[i+4] != din[i]) mism++;
      if (cap_n[i+4]) both++;
    end
    check(mism == 0, "R9", "positive rail equals delayed data", mism, 0);
    check(both == 0, "R9", "negative rail pulses in unipolar", both, 0);
    unipolar = 1'b0; idle_edge();
    for (int k = 0; k < 2; k++) begin
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    end
    send_bit(1'b1);
    send_tail();
    analyze(16, ncap, 3, 1'b0, mism, bpv, exz, perr, both);
    check(bpv == 0, "R9", "BPV after leaving unipolar", bpv, 0);
    check(exz == 0, "R9", "EXZ after leaving unipolar", exz, 0);
    check(mism == 0, "R9", "decoded data after leaving unipolar", mism, 0);
    bpv_ctl = 1'b0; exz_ctl = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule